// File: doc/BRIEF.md
# Tagged Memory Access Checker

This block is the front end of a load/store path with a small local data store and a separate lock-tag store. The data store is divided into aligned 16-byte granules, and each granule carries one 4-bit lock tag. Every request carries a 64-bit pointer whose top byte holds a 4-bit key tag. For checked accesses the block compares the key tag with the lock tag of the addressed granule and reports a fault when they differ. The block also offers operations that re-tag a granule, operations that fill a granule and tag it in one step, and an unchecked path for stack-relative accesses.

Requests enter on a valid/ready stream and responses leave on a second valid/ready stream. The request side accepts a beat when `req_valid` and `req_ready` are both high. `req_ready` is low only while a response is held because `rsp_ready` is low. The response appears in the cycle after acceptance. While it waits for `rsp_ready`, its payload stays unchanged. A sticky fault flag and the full pointer of the first faulting access are exposed as plain status pins, and a plain clear input resets them.

Tag matching works only at granule resolution. A pointer that strays past the end of an allocation, but stays inside the allocation's last granule, uses the same lock tag and is not detected.

Top module: `tcl_tagged_lsu`

## Requirements
- R1: After reset every lock tag and every data word is zero, `rsp_valid` is 0 and `fault_flag` is 0. A pointer with key tag 0 therefore passes any check until a granule is re-tagged.
- R2: The key tag is pointer bits 59:56. Bits 63:60 are ignored. The byte address is pointer bits 55:0. The granule index is address bits [GRAN_LOG2+3:4]; address bits above that range are ignored. Address bit 3 selects the lower (0) or upper (1) 64-bit word of the granule, and bits 2:0 are ignored.
- R3: A checked load (`req_op` = 0) whose key tag equals the lock tag returns the addressed word with `rsp_fault` = 0.
- R4: A checked store (`req_op` = 1) whose key tag equals the lock tag writes `req_data0` to the addressed word and responds with `rsp_fault` = 0.
- R5: On a checked load or store whose key tag differs from the lock tag, the response has `rsp_fault` = 1 and `rsp_rdata` = 0, and a store leaves memory unchanged.
- R6: A tag-set (`req_op` = 2) writes the key tag into the granule's lock tag, leaves the data unchanged and never faults.
- R7: A pair-store-and-tag (`req_op` = 3) writes `req_data0` to the lower word and `req_data1` to the upper word, and sets the lock tag to the key tag, in one operation and without a check.
- R8: Stack-relative load (`req_op` = 4) and store (`req_op` = 5) use the address pointer bits 55:0 plus the sign-extended `req_imm`. They skip the tag check and never fault.
- R9: A response is valid in the cycle after acceptance and holds its payload while `rsp_ready` is low. `req_ready` equals `!rsp_valid || rsp_ready`.
- R10: The first fault sets `fault_flag` and latches the full pointer in `fault_addr`. Later faults do not overwrite it. `fault_clear` clears the flag, but a fault accepted in the same cycle as the clear is recorded as a new first fault.
- R11: Operation codes 6 and 7 change no state and respond with `rsp_rdata` = 0 and `rsp_fault` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request beat valid |
| req_ready | output | 1 | Request beat can be taken |
| req_op | input | 3 | Operation code |
| req_ptr | input | 64 | Tagged pointer |
| req_imm | input | 12 | Signed offset for stack-relative operations |
| req_data0 | input | 64 | Store data, or lower word of a pair |
| req_data1 | input | 64 | Upper word of a pair |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response can be taken |
| rsp_rdata | output | 64 | Load data, zero otherwise |
| rsp_fault | output | 1 | Tag mismatch on this access |
| fault_clear | input | 1 | Clears the sticky fault record |
| fault_flag | output | 1 | Sticky fault indication |
| fault_addr | output | 64 | Pointer of the recorded fault |

## Verification
The case that is hardest to reach from the ports is a tag mismatch that is accepted in the same cycle as `fault_clear`, while an older fault is still recorded. It needs a re-tagged granule, a first recorded fault, and then a second faulting request timed against the clear pulse. The directed part of the stimulus builds exactly that sequence. The random part then mixes operations under random response back-pressure. Half of its key tags are copied from the model's lock tag, so hits, misses, held responses and fault records all interleave.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  localparam int PTR_W   = 64;
  localparam int WORD_W  = 64;
  localparam int TAG_W   = 4;
  localparam int IMM_W   = 12;
  localparam int ADDR_W  = 56;
  localparam int KEY_LO  = 56;

  typedef enum logic [2:0] {
    OP_LOAD    = 3'd0,
    OP_STORE   = 3'd1,
    OP_TAGSET  = 3'd2,
    OP_STPAIR  = 3'd3,
    OP_SPLOAD  = 3'd4,
    OP_SPSTORE = 3'd5,
    OP_RSV6    = 3'd6,
    OP_RSV7    = 3'd7
  } tcl_op_e;

  typedef struct packed {
    logic checked;
    logic rd_word;
    logic wr_word;
    logic set_tag;
    logic wr_pair;
    logic sp_rel;
  } tcl_ctl_t;

  function automatic tcl_ctl_t tcl_decode_op(tcl_op_e op);
    tcl_ctl_t c;
    c = '0;
    case (op)
      OP_LOAD:    begin c.checked = 1'b1; c.rd_word = 1'b1; end
      OP_STORE:   begin c.checked = 1'b1; c.wr_word = 1'b1; end
      OP_TAGSET:  c.set_tag = 1'b1;
      OP_STPAIR:  begin c.set_tag = 1'b1; c.wr_pair = 1'b1; end
      OP_SPLOAD:  begin c.rd_word = 1'b1; c.sp_rel = 1'b1; end
      OP_SPSTORE: begin c.wr_word = 1'b1; c.sp_rel = 1'b1; end
      default:    c = '0;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/tcl_addr_decode.sv
module tcl_addr_decode
  import tcl_pkg::*;
#(
  parameter int GRAN_LOG2 = 4
) (
  input  tcl_op_e                op,
  input  logic [PTR_W-1:0]       ptr,
  input  logic [IMM_W-1:0]       imm,
  output logic [GRAN_LOG2-1:0]   gran_idx,
  output logic                   word_sel,
  output logic [TAG_W-1:0]       key_tag,
  output tcl_ctl_t               ctl
);
  localparam int IDX_HI = GRAN_LOG2 + 3;

  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;
  logic [ADDR_W-1:0] eff;
  logic              unused_bits;

  assign ctl      = tcl_decode_op(op);
  assign base     = ptr[ADDR_W-1:0];
  assign offs     = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
  // Only the stack-relative path adds the immediate offset.
  assign eff      = ctl.sp_rel ? (base + offs) : base;
  assign gran_idx = eff[IDX_HI:4];
  assign word_sel = eff[3];
  assign key_tag  = ptr[KEY_LO+TAG_W-1:KEY_LO];

  assign unused_bits = ^{ptr[PTR_W-1:KEY_LO+TAG_W], eff[2:0], eff[ADDR_W-1:IDX_HI+1]};
endmodule

// File: rtl/tcl_tag_ram.sv
module tcl_tag_ram
  import tcl_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEPTH_LOG2-1:0] rd_idx,
  output logic [TAG_W-1:0]      rd_tag,
  input  logic                  wr_en,
  input  logic [DEPTH_LOG2-1:0] wr_idx,
  input  logic [TAG_W-1:0]      wr_tag
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [TAG_W-1:0] locks [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) locks[i] <= '0;
    end else if (wr_en) begin
      locks[wr_idx] <= wr_tag;
    end
  end

  assign rd_tag = locks[rd_idx];

  // R6/R7: a tag write is visible on the next cycle.
  assert_tag_written_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_idx == wr_idx) |=> (rd_idx != $past(wr_idx)) || (rd_tag == $past(wr_tag)));
endmodule

// File: rtl/tcl_data_ram.sv
module tcl_data_ram
  import tcl_pkg::*;
#(
  parameter int DEPTH_LOG2 = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [DEPTH_LOG2-1:0]        rd_idx,
  input  logic                         rd_sel,
  output logic [WORD_W-1:0]            rd_data,
  input  logic [DEPTH_LOG2-1:0]        wr_idx,
  input  logic [1:0]                   wr_en,
  input  logic [1:0][WORD_W-1:0]       wr_data
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [1:0][WORD_W-1:0] bank_rd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] words [DEPTH];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) words[i] <= '0;
      end else if (wr_en[b]) begin
        words[wr_idx] <= wr_data[b];
      end
    end
    assign bank_rd[b] = words[rd_idx];
  end

  assign rd_data = bank_rd[rd_sel];
endmodule

// File: rtl/tcl_fault_log.sv
module tcl_fault_log
  import tcl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fault_evt,
  input  logic [PTR_W-1:0] fault_ptr,
  input  logic             clear,
  output logic             flag,
  output logic [PTR_W-1:0] addr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0;
      addr <= '0;
    end else if (fault_evt && (!flag || clear)) begin
      flag <= 1'b1;
      addr <= fault_ptr;
    end else if (clear) begin
      flag <= 1'b0;
    end
  end

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clear) |=> (flag && $stable(addr)));

  assert_clear_race_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_evt && clear) |=> (flag && addr == $past(fault_ptr)));
endmodule

// File: rtl/tcl_tagged_lsu.sv
module tcl_tagged_lsu
  import tcl_pkg::*;
#(
  parameter int GRAN_LOG2 = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_op,
  input  logic [63:0] req_ptr,
  input  logic [11:0] req_imm,
  input  logic [63:0] req_data0,
  input  logic [63:0] req_data1,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [63:0] rsp_rdata,
  output logic        rsp_fault,
  input  logic        fault_clear,
  output logic        fault_flag,
  output logic [63:0] fault_addr
);
  logic [GRAN_LOG2-1:0]   gran_idx;
  logic                   word_sel;
  logic [TAG_W-1:0]       key_tag;
  logic [TAG_W-1:0]       lock_tag;
  tcl_ctl_t               ctl;
  logic                   accept;
  logic                   mismatch;
  logic                   tag_we;
  logic [1:0]             word_we;
  logic [1:0][WORD_W-1:0] word_wd;
  logic [WORD_W-1:0]      rd_word;

  tcl_addr_decode #(.GRAN_LOG2(GRAN_LOG2)) u_decode (
    .op       (tcl_op_e'(req_op)),
    .ptr      (req_ptr),
    .imm      (req_imm),
    .gran_idx (gran_idx),
    .word_sel (word_sel),
    .key_tag  (key_tag),
    .ctl      (ctl)
  );

  tcl_tag_ram #(.DEPTH_LOG2(GRAN_LOG2)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (gran_idx),
    .rd_tag (lock_tag),
    .wr_en  (tag_we),
    .wr_idx (gran_idx),
    .wr_tag (key_tag)
  );

  tcl_data_ram #(.DEPTH_LOG2(GRAN_LOG2)) u_data (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (gran_idx),
    .rd_sel  (word_sel),
    .rd_data (rd_word),
    .wr_idx  (gran_idx),
    .wr_en   (word_we),
    .wr_data (word_wd)
  );

  tcl_fault_log u_faults (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault_evt (accept && mismatch),
    .fault_ptr (req_ptr),
    .clear     (fault_clear),
    .flag      (fault_flag),
    .addr      (fault_addr)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign mismatch  = ctl.checked && (key_tag != lock_tag);
  assign tag_we    = accept && ctl.set_tag;

  always_comb begin
    word_we[0] = accept && (ctl.wr_pair || (ctl.wr_word && !mismatch && !word_sel));
    word_we[1] = accept && (ctl.wr_pair || (ctl.wr_word && !mismatch && word_sel));
    word_wd[0] = req_data0;
    word_wd[1] = ctl.wr_pair ? req_data1 : req_data0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_fault <= 1'b0;
    end else if (accept) begin
      rsp_valid <= 1'b1;
      rsp_rdata <= (ctl.rd_word && !mismatch) ? rd_word : '0;
      rsp_fault <= mismatch;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> rsp_valid);

  assert_rsp_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_fault)));

  assert_fault_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_rdata == '0));

  assert_unchecked_nofault_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_op >= 3'd2) |=> !rsp_fault);

  assert_fault_sets_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && $changed(rsp_fault)) |-> fault_flag);
endmodule

// File: tb/tcl_tagged_lsu_tb.sv
module tcl_tagged_lsu_tb;
  localparam int CLK_PERIOD = 10;
  localparam int GL = 4;
  localparam int NG = 1 << GL;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [2:0]  req_op = 0;
  logic [63:0] req_ptr = 0;
  logic [11:0] req_imm = 0;
  logic [63:0] req_data0 = 0;
  logic [63:0] req_data1 = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic [63:0] rsp_rdata;
  logic        rsp_fault;
  logic        fault_clear = 0;
  logic        fault_flag;
  logic [63:0] fault_addr;

  tcl_tagged_lsu #(.GRAN_LOG2(GL)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  bit bp_en  = 0;

  // Reference model state
  logic [3:0]  m_tag  [NG];
  logic [63:0] m_data [NG][2];
  logic        e_valid, e_fault, e_flag;
  logic [63:0] e_rdata, e_faddr;
  string       e_tag = "R1";

  always @(posedge clk) begin
    logic acc, flt, w;
    logic [55:0] a;
    int g;
    logic [3:0] key;
    if (!rst_n) begin
      for (int i = 0; i < NG; i++) begin
        m_tag[i] = 0; m_data[i][0] = 0; m_data[i][1] = 0;
      end
      e_valid = 0; e_fault = 0; e_rdata = 0; e_flag = 0; e_faddr = 0;
    end else begin
      acc = req_valid && (!e_valid || rsp_ready);
      flt = 0;
      if (acc) begin
        a = req_ptr[55:0];
        if (req_op == 4 || req_op == 5) a = a + {{44{req_imm[11]}}, req_imm};
        g = int'(a[GL+3:4]);
        w = a[3];
        key = req_ptr[59:56];
        e_valid = 1; e_rdata = 0; e_fault = 0;
        case (req_op)
          3'd0: begin
            if (key != m_tag[g]) begin flt = 1; e_tag = "R5"; end
            else begin e_rdata = m_data[g][w]; e_tag = "R2/R3"; end
          end
          3'd1: begin
            if (key != m_tag[g]) begin flt = 1; e_tag = "R5"; end
            else begin m_data[g][w] = req_data0; e_tag = "R4"; end
          end
          3'd2: begin m_tag[g] = key; e_tag = "R6"; end
          3'd3: begin
            m_tag[g] = key; m_data[g][0] = req_data0; m_data[g][1] = req_data1; e_tag = "R7";
          end
          3'd4: begin e_rdata = m_data[g][w]; e_tag = "R8"; end
          3'd5: begin m_data[g][w] = req_data0; e_tag = "R8"; end
          default: e_tag = "R11";
        endcase
        e_fault = flt;
      end else if (rsp_ready) begin
        e_valid = 0;
      end
      if (flt && (!e_flag || fault_clear)) begin
        e_flag = 1; e_faddr = req_ptr;
      end else if (fault_clear) begin
        e_flag = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(rsp_valid == 0, "R1", 64'(rsp_valid), 0);
        chk(fault_flag == 0, "R1", 64'(fault_flag), 0);
      end else begin
        chk(req_ready == (!e_valid || rsp_ready), "R9", 64'(req_ready), 64'(!e_valid || rsp_ready));
        chk(rsp_valid == e_valid, "R9", 64'(rsp_valid), 64'(e_valid));
        if (e_valid) begin
          chk(rsp_rdata == e_rdata, e_tag, rsp_rdata, e_rdata);
          chk(rsp_fault == e_fault, e_tag, 64'(rsp_fault), 64'(e_fault));
        end
        chk(fault_flag == e_flag, "R10", 64'(fault_flag), 64'(e_flag));
        if (e_flag) chk(fault_addr == e_faddr, "R10", fault_addr, e_faddr);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    rsp_ready = bp_en ? 1'($urandom % 2) : 1'b1;
  end

  function automatic logic [63:0] mkptr(input logic [3:0] junk, input logic [3:0] key,
                                        input int g, input logic w, input logic [2:0] lo);
    logic [63:0] p;
    p = {junk, key, 48'h00ab_cd00_0000 + 48'($urandom % 4096), 8'h00};
    p[GL+3:4] = g[GL-1:0];
    p[3] = w;
    p[2:0] = lo;
    return p;
  endfunction

  task automatic req(input logic [2:0] op, input logic [63:0] ptr, input logic [11:0] imm,
                     input logic [63:0] d0, input logic [63:0] d1, input bit clr = 0);
    bit ok;
    req_valid = 1; req_op = op; req_ptr = ptr; req_imm = imm;
    req_data0 = d0; req_data1 = d1; fault_clear = clr;
    do begin
      @(negedge clk); ok = req_ready;
      @(posedge clk); #2;
      fault_clear = 0;
    end while (!ok);
    req_valid = 0;
  endtask

  task automatic idle(input int n, input bit clr = 0);
    fault_clear = clr;
    repeat (n) begin @(posedge clk); #2; fault_clear = 0; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    idle(1);
    // R1: untagged pointers read zero without fault
    for (int g = 0; g < NG; g++) req(3'd0, mkptr(4'h0, 4'h0, g, g[0], 0), 0, 0, 0);
    // R4 then R2/R3: plain store/load with tag 0, junk in bits 63:60 and 2:0
    req(3'd1, mkptr(4'hF, 4'h0, 2, 1, 3'h5), 0, 64'h1111_2222_3333_4444, 0);
    req(3'd0, mkptr(4'h9, 4'h0, 2, 1, 3'h2), 0, 0, 0);
    req(3'd0, mkptr(4'h0, 4'h0, 2, 0, 3'h0), 0, 0, 0);
    // R6: re-tag granule 2, data kept
    req(3'd2, mkptr(4'h5, 4'hA, 2, 0, 0), 0, 64'hdead, 0);
    req(3'd0, mkptr(4'h0, 4'hA, 2, 1, 0), 0, 0, 0);
    // R5/R10: stale key faults, first fault recorded
    req(3'd0, mkptr(4'h0, 4'h0, 2, 1, 0), 0, 0, 0);
    req(3'd1, mkptr(4'h0, 4'h3, 2, 1, 0), 0, 64'hbad, 0);
    req(3'd0, mkptr(4'h0, 4'hA, 2, 1, 0), 0, 0, 0);
    // R7: pair store and tag, then both halves
    req(3'd3, mkptr(4'h0, 4'h7, 5, 0, 0), 0, 64'hAAAA_0001, 64'hBBBB_0002);
    req(3'd0, mkptr(4'h0, 4'h7, 5, 0, 3'h7), 0, 0, 0);
    req(3'd0, mkptr(4'h0, 4'h7, 5, 1, 3'h1), 0, 0, 0);
    // R8: stack-relative with negative offset ignores tag
    req(3'd5, mkptr(4'h0, 4'h0, 6, 0, 0), 12'hFF8, 64'h5555_6666, 0);
    req(3'd4, mkptr(4'h0, 4'h2, 6, 0, 0), 12'hFF8, 0, 0);
    req(3'd4, mkptr(4'h0, 4'h0, 4, 1, 0), 12'h010, 0, 0);
    // R10: clear, then fault in same cycle as clear with a fault recorded
    idle(1, 1);
    req(3'd0, mkptr(4'h0, 4'h1, 5, 0, 0), 0, 0, 0);
    req(3'd0, mkptr(4'h0, 4'h2, 5, 1, 0), 0, 0, 0, 1);
    idle(2);
    // R11: reserved codes change nothing
    req(3'd6, mkptr(4'h0, 4'h9, 5, 0, 0), 0, 64'h77, 64'h88);
    req(3'd7, mkptr(4'h0, 4'h9, 5, 1, 0), 0, 64'h77, 64'h88);
    req(3'd0, mkptr(4'h0, 4'h7, 5, 0, 0), 0, 0, 0);
    // Random mix under back-pressure
    bp_en = 1;
    for (int i = 0; i < 600; i++) begin
      int g;
      logic [3:0] k;
      g = int'($urandom % NG);
      k = ($urandom % 2) ? m_tag[g] : 4'($urandom);
      req(3'($urandom), mkptr(4'($urandom), k, g, 1'($urandom), 3'($urandom)),
          ($urandom % 2) ? 12'h0 : 12'($urandom % 64) - 12'd32,
          {$urandom, $urandom}, {$urandom, $urandom}, ($urandom % 8) == 0);
    end
    bp_en = 0;
    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule